// File: doc/BRIEF.md
# Wrapping Burst Address Sequencer

This block produces the sequence of double-word addresses for one burst on a system bus that moves whole cache lines. A line is either four 8-byte beats (32 bytes) or eight beats (64 bytes), and the choice is made per burst. When the block is idle, a load pulse captures a start address, a line-size select and an ordering mode. The ordering mode is either critical-word-first, which begins at the requested double word and wraps within the line, or zero-word-first, which begins at the line-aligned double word.

After the load, the block presents one beat address at a time. It moves to the next beat in the clock after the beat acknowledge is sampled high, and it holds while the acknowledge is low. It reports the beat index and a flag that is high while the final beat is outstanding. When the final beat is acknowledged, a one-cycle done pulse follows and the block returns to idle. Bus handshaking and data storage belong to the surrounding logic.

The controller has two states. In `ST_IDLE`, a load moves it to `ST_RUN` through the transition *start*, and all other inputs are ignored. In `ST_RUN`, an acknowledge on the last beat returns it to `ST_IDLE` through the transition *finish*, and a load is ignored.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `active_o`, `done_o` and `last_o` are 0, and `beat_addr_o` and `beat_idx_o` are 0.
- R2: A `load_i` that is sampled high while idle starts a burst. In the next cycle `active_o` is 1 and `beat_idx_o` is 0.
- R3: With `crit_first_i`=1, the first beat address equals the start address with bits [2:0] cleared.
- R4: With `crit_first_i`=0, the first beat address is line-aligned. Bits [4:3] are zero for a 4-beat line and bits [5:3] are zero for an 8-beat line.
- R5: Beat k has address line_base + ((s + k) mod N) * 8. Here N is the beat count, s is the first beat's double-word offset within the line, and line_base is the start address with its low 5 bits (N=4) or low 6 bits (N=8) cleared. The bits above the line offset never change during a burst.
- R6: While `ack_i` is low during a burst, `beat_addr_o` and `beat_idx_o` hold.
- R7: `last_o` is 1 exactly while `beat_idx_o` equals N-1 during a burst.
- R8: In the cycle after the N-th acknowledge, `done_o` is 1 for one cycle, `active_o` is 0, and `beat_addr_o`, `beat_idx_o` and `last_o` read 0 for as long as the block is idle.
- R9: `beat_addr_o[2:0]` is always zero.
- R10: A `load_i` during a burst is ignored. The addresses, ordering and length of the running burst are unchanged.
- R11: `long_line_i`=1 selects an 8-beat (64-byte) line and `long_line_i`=0 selects a 4-beat (32-byte) line. Both are captured at load.
- R12: `ack_i` while idle has no effect. `active_o` and `done_o` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Start a burst (honoured only when idle) |
| start_addr_i | input | ADDR_W (32) | Requested byte address |
| long_line_i | input | 1 | 1: 8-beat line, 0: 4-beat line |
| crit_first_i | input | 1 | 1: critical-word-first, 0: zero-word-first |
| ack_i | input | 1 | Beat acknowledge |
| active_o | output | 1 | Burst in progress |
| beat_addr_o | output | ADDR_W (32) | Current beat address |
| beat_idx_o | output | OFS_W (3) | Beats already acknowledged in this burst |
| last_o | output | 1 | Final beat outstanding |
| done_o | output | 1 | One-cycle pulse after the final beat is acknowledged |

## Verification
The bench builds the block with its default parameters: a 32-bit address, 8-byte beats and a longest line of 8 beats. With these values both line sizes and both orderings can be exercised on the same instance. Random start addresses reach every start offset, so every wrap point is covered. An all-ones upper address checks that the line bits never carry upward. Random acknowledge densities produce long holds as well as back-to-back beats, and loads issued mid-burst test that the captured burst is protected.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
    import burst_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic       ack_i,
    input  logic       last_i,
    output seq_state_e state_o,
    output logic       start_o,
    output logic       adv_o,
    output logic       done_o
);
    seq_state_e state_q, state_d;
    logic       done_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_RUN) && ack_i && last_i;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        start_o = 1'b0;
        adv_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (load_i) begin
                    start_o = 1'b1;        // transition: start
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                adv_o = ack_i;
                if (ack_i && last_i) begin
                    state_d = ST_IDLE;     // transition: finish
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign state_o = state_q;
    assign done_o  = done_q;

    // R8: done lasts a single cycle and coincides with idle
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (state_q == ST_IDLE));
    // R12: acknowledge while idle does not start anything
    p_idle_ack_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) && !load_i |=> (state_q == ST_IDLE) && !done_o);
endmodule

// File: rtl/beat_counter.sv
module beat_counter #(
    parameter int OFS_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             long_i,
    input  logic             adv_i,
    output logic [OFS_W-1:0] cnt_o,
    output logic             last_o
);
    localparam logic [OFS_W-1:0] LIM_LONG  = {OFS_W{1'b1}};
    localparam logic [OFS_W-1:0] LIM_SHORT = {1'b0, {(OFS_W-1){1'b1}}};

    logic [OFS_W-1:0] cnt_q;
    logic [OFS_W-1:0] lim_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= LIM_SHORT;
        end else if (start_i) begin
            cnt_q <= '0;
            lim_q <= long_i ? LIM_LONG : LIM_SHORT;
        end else if (adv_i) begin
            cnt_q <= last_o ? '0 : cnt_q + 1'b1;
        end
    end

    assign cnt_o  = cnt_q;
    assign last_o = (cnt_q == lim_q);

    // R7: the count never passes the captured limit
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim_q);
    // R6: no advance means the count holds
    p_cnt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i && !start_i |=> $stable(cnt_q));
endmodule

// File: rtl/addr_wrap.sv
module addr_wrap #(
    parameter int ADDR_W = 32,
    parameter int BYTE_W = 3,
    parameter int OFS_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              long_i,
    input  logic              crit_i,
    input  logic [OFS_W-1:0]  cnt_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int HI_W = ADDR_W - OFS_W - BYTE_W;
    localparam logic [OFS_W-1:0] MASK_LONG  = {OFS_W{1'b1}};
    localparam logic [OFS_W-1:0] MASK_SHORT = {1'b0, {(OFS_W-1){1'b1}}};

    logic [ADDR_W-1:0] base_q;
    logic [OFS_W-1:0]  sofs_q;
    logic [OFS_W-1:0]  mask_q;
    logic [OFS_W-1:0]  mask_sel;
    logic [ADDR_W-1:0] keep_bits;
    logic [OFS_W-1:0]  wofs;

    always_comb begin
        mask_sel  = long_i ? MASK_LONG : MASK_SHORT;
        keep_bits = {{HI_W{1'b1}}, ~mask_sel, {BYTE_W{1'b0}}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            sofs_q <= '0;
            mask_q <= MASK_SHORT;
        end else if (start_i) begin
            base_q <= addr_i & keep_bits;
            sofs_q <= crit_i ? (addr_i[BYTE_W +: OFS_W] & mask_sel) : '0;
            mask_q <= mask_sel;
        end
    end

    assign wofs   = (sofs_q + cnt_i) & mask_q;
    assign addr_o = base_q | {{HI_W{1'b0}}, wofs, {BYTE_W{1'b0}}};

    // R10: captured burst parameters only change on an accepted load
    p_capture_only_on_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(base_q) && $stable(sofs_q) && $stable(mask_q));
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BEAT_BYTES = 8,
    parameter int LONG_BEATS = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load_i,
    input  logic [ADDR_W-1:0]             start_addr_i,
    input  logic                          long_line_i,
    input  logic                          crit_first_i,
    input  logic                          ack_i,
    output logic                          active_o,
    output logic [ADDR_W-1:0]             beat_addr_o,
    output logic [$clog2(LONG_BEATS)-1:0] beat_idx_o,
    output logic                          last_o,
    output logic                          done_o
);
    localparam int BYTE_W = $clog2(BEAT_BYTES);
    localparam int OFS_W  = $clog2(LONG_BEATS);
    localparam int LINE_W = BYTE_W + OFS_W;

    seq_state_e        state;
    logic              start, adv, cnt_last;
    logic [OFS_W-1:0]  cnt;
    logic [ADDR_W-1:0] raw_addr;
    logic              run;

    burst_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_i),
        .ack_i   (ack_i),
        .last_i  (cnt_last),
        .state_o (state),
        .start_o (start),
        .adv_o   (adv),
        .done_o  (done_o)
    );

    beat_counter #(.OFS_W(OFS_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .long_i  (long_line_i),
        .adv_i   (adv),
        .cnt_o   (cnt),
        .last_o  (cnt_last)
    );

    addr_wrap #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .OFS_W(OFS_W)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .addr_i  (start_addr_i),
        .long_i  (long_line_i),
        .crit_i  (crit_first_i),
        .cnt_i   (cnt),
        .addr_o  (raw_addr)
    );

    assign run         = (state == ST_RUN);
    assign active_o    = run;
    assign beat_addr_o = run ? raw_addr : '0;
    assign beat_idx_o  = run ? cnt : '0;
    assign last_o      = run && cnt_last;

    // R9: beat addresses are double-word aligned
    p_align_r9: assert property (@(posedge clk) disable iff (!rst_n)
        beat_addr_o[BYTE_W-1:0] == '0);
    // R6: no acknowledge, nothing moves
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        active_o && !ack_i |=> active_o && $stable(beat_addr_o) && $stable(beat_idx_o));
    // R5: the index steps by one on each non-final acknowledge
    p_idx_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        active_o && ack_i && !last_o |=> active_o && (beat_idx_o == $past(beat_idx_o) + 1'b1));
    // R5: the line address above the offset field stays fixed
    p_upper_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        active_o && $past(active_o) |-> beat_addr_o[ADDR_W-1:LINE_W] == $past(beat_addr_o[ADDR_W-1:LINE_W]));
    // R8: final acknowledge ends the burst with a done pulse
    p_finish_r8: assert property (@(posedge clk) disable iff (!rst_n)
        active_o && ack_i && last_o |=> !active_o && done_o);
    // R2: an idle load starts at beat zero
    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !active_o && load_i |=> active_o && (beat_idx_o == '0));
endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_i = 1'b0;
    logic [31:0] start_addr_i = '0;
    logic        long_line_i = 1'b0;
    logic        crit_first_i = 1'b0;
    logic        ack_i = 1'b0;
    logic        active_o, last_o, done_o;
    logic [31:0] beat_addr_o;
    logic [2:0]  beat_idx_o;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_seq u_dut (
        .clk (clk), .rst_n (rst_n), .load_i (load_i),
        .start_addr_i (start_addr_i), .long_line_i (long_line_i),
        .crit_first_i (crit_first_i), .ack_i (ack_i),
        .active_o (active_o), .beat_addr_o (beat_addr_o),
        .beat_idx_o (beat_idx_o), .last_o (last_o), .done_o (done_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_addr(input logic [31:0] a, input logic lng,
                                            input logic crit, input int k);
        int n;
        logic [31:0] base, s;
        n    = lng ? 8 : 4;
        base = a & ~(lng ? 32'h3F : 32'h1F);
        s    = crit ? ((a >> 3) & (n - 1)) : 0;
        return base + (((s + k) % n) << 3);
    endfunction

    // runs one burst; pct = acknowledge probability, mid_load = issue loads mid-burst
    task automatic run_burst(input logic [31:0] a, input logic lng, input logic crit,
                             input int pct, input bit mid_load);
        int n, k;
        bit took, hold;
        n = lng ? 8 : 4;
        @(negedge clk);
        load_i = 1'b1; start_addr_i = a; long_line_i = lng; crit_first_i = crit;
        @(negedge clk);
        load_i = 1'b0;
        chk("R2 active", {31'b0, active_o}, 32'd1);
        chk("R2 idx0", {29'b0, beat_idx_o}, 32'd0);
        if (crit) chk("R3 first addr", beat_addr_o, a & ~32'h7);
        else      chk("R4 first addr", beat_addr_o, a & ~(lng ? 32'h3F : 32'h1F));
        k = 0; hold = 1'b0;
        while (k < n) begin
            chk(hold ? "R6 hold addr" : "R5 addr", beat_addr_o, exp_addr(a, lng, crit, k));
            chk("R5 idx", {29'b0, beat_idx_o}, k);
            chk("R7 last", {31'b0, last_o}, (k == n - 1) ? 32'd1 : 32'd0);
            chk("R9 align", {29'b0, beat_addr_o[2:0]}, 32'd0);
            took = ($urandom % 100) < pct;
            ack_i = took;
            if (mid_load && ($urandom % 3 == 0)) begin
                load_i = 1'b1; start_addr_i = $urandom;  // R10: must be ignored
                long_line_i = ~lng; crit_first_i = ~crit;
            end
            @(negedge clk);
            ack_i = 1'b0; load_i = 1'b0;
            if (took) k++;
            hold = !took;
        end
        chk("R8 done", {31'b0, done_o}, 32'd1);
        chk("R8 idle", {31'b0, active_o}, 32'd0);
        chk("R8 addr zero", beat_addr_o, 32'd0);
        chk("R11 beats", k, n);
        @(negedge clk);
        chk("R8 done one cycle", {31'b0, done_o}, 32'd0);
        chk("R8 idx zero", {29'b0, beat_idx_o}, 32'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        #(CLK_PERIOD * 3);
        @(negedge clk);
        chk("R1 active", {31'b0, active_o}, 32'd0);
        chk("R1 done", {31'b0, done_o}, 32'd0);
        chk("R1 addr", beat_addr_o, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 last", {31'b0, last_o}, 32'd0);
        chk("R1 idx", {29'b0, beat_idx_o}, 32'd0);
        // R12: acknowledges while idle
        for (int i = 0; i < 3; i++) begin
            ack_i = 1'b1;
            @(negedge clk);
            ack_i = 1'b0;
            chk("R12 idle stays", {31'b0, active_o}, 32'd0);
            chk("R12 no done", {31'b0, done_o}, 32'd0);
        end
        // directed corners
        run_burst(32'h0000_1038, 1'b1, 1'b1, 100, 1'b0); // R5 wrap from last word, long
        run_burst(32'h0000_1018, 1'b0, 1'b1, 100, 1'b0); // R5 wrap, short
        run_burst(32'hFFFF_FFFF, 1'b1, 1'b1, 50, 1'b0);  // R5 upper bits fixed
        run_burst(32'hFFFF_FFFF, 1'b0, 1'b0, 50, 1'b0);  // R4 short zero-word-first
        run_burst(32'h0000_2030, 1'b0, 1'b1, 100, 1'b0); // R11 short keeps bit 5
        run_burst(32'h0000_2030, 1'b1, 1'b0, 30, 1'b1);  // R10 loads mid-burst
        // random
        for (int i = 0; i < 60; i++) begin
            run_burst($urandom, 1'($urandom), 1'($urandom), 20 + ($urandom % 81), 1'($urandom));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule